// File: doc/BRIEF.md
# Entropy Stream Health Monitor

This block watches the raw bit stream coming out of a noise source and raises a one-cycle failure pulse whenever a statistical or repetition check on that stream fails. Each pulse is meant to set a sticky bit in a status register that sits outside this block. The checks all run at the same time on the same stream.

Two checks work on fixed windows of 20,000 accepted bits, and each starts again from zero at the next window: a ones-count test and a 4-bit pattern-frequency test. Two run-length detectors work without windows. One flags a run of 34 identical bits and the other a run of 48. A separate check compares each 128-bit output block with the block before it and flags an exact repeat.

A synchronous clear input restarts the window statistics and forgets the stored block. The run-length detectors are not affected by clear.

Top module: `entropy_health_mon`

## Requirements
- R1: After reset every fail output is low. Each fail output is registered and goes high for exactly one cycle, in the cycle after the input sample that caused it.
- R2: Only cycles with bit_valid high count toward a window. Once 20,000 such bits have been accepted, fail_mono pulses if the number of ones is 9,654 or fewer, or 10,346 or more. The count then restarts from zero.
- R3: The window is cut into 5,000 back-to-back 4-bit groups. The first bit of each group is its MSB. Let c[v] be the number of groups with value v. fail_poker pulses at the end of the window unless 16·Σc[v]² − 25,000,000 is strictly greater than 5,150 and strictly less than 287,000.
- R4: fail_long pulses once, when a run of equal accepted bits reaches 34. It does not pulse again while that run continues.
- R5: fail_noise pulses once, when a run of equal accepted bits reaches 48.
- R6: A run carries on across window boundaries, across cycles with bit_valid low, and across clear.
- R7: When blk_valid is high and blk_data equals the previously accepted block, fail_stuck pulses. The first block after reset, or after a clear, never causes a pulse.
- R8: A cycle with clr high resets the window counters, the partial 4-bit group and the stored block. In that cycle clr takes priority over bit_valid and blk_valid for the window and block checks.
- R9: Cycles with bit_valid low do not advance the window, the ones count or the 4-bit grouping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of window and block state |
| bit_valid | input | 1 | bit_in carries a new source bit |
| bit_in | input | 1 | Source bit |
| blk_valid | input | 1 | blk_data carries a new output block |
| blk_data | input | BLK_W | Output block to compare |
| fail_mono | output | 1 | Ones-count failure pulse |
| fail_poker | output | 1 | Pattern-frequency failure pulse |
| fail_long | output | 1 | 34-bit run failure pulse |
| fail_noise | output | 1 | 48-bit run failure pulse |
| fail_stuck | output | 1 | Repeated block failure pulse |

## Verification
The ones-count limits are the hardest thing to reach from the ports. A window must hold exactly 10,346 or 9,655 ones, and nothing else in it may trip a run detector. The bench spreads a chosen number of ones evenly over 20,000 bits with an error-accumulation rule, so the longest run in such a window is two bits.

A second awkward case is a run that spans a clear. The bench sends 20 ones, pulses clear, and then keeps sending ones. The long-run pulse must then come 14 bits after the clear and the noise pulse 28 bits after it.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
  localparam int GRP_W   = 4;
  localparam int NUM_PAT = 1 << GRP_W;
endpackage

// File: rtl/ehm_window_stats.sv
module ehm_window_stats #(
  parameter int WIN_BITS = 20000,
  parameter int ONES_LO  = 9654,
  parameter int ONES_HI  = 10346,
  parameter int PK_LO    = 5150,
  parameter int PK_HI    = 287000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_valid,
  input  logic bit_in,
  output logic fail_mono,
  output logic fail_poker
);
  import ehm_pkg::*;
  localparam int CNT_W = $clog2(WIN_BITS + 1);
  localparam int NIBS  = WIN_BITS / GRP_W;
  localparam int PC_W  = $clog2(NIBS + 1);
  localparam int SQ_W  = 2 * PC_W + GRP_W;
  localparam int ST_W  = SQ_W + GRP_W + 1;

  logic [CNT_W-1:0] bit_cnt, ones_cnt, ones_nxt;
  logic [GRP_W-1:0] grp_sr, grp_full;
  logic [1:0]       grp_pos;
  logic [PC_W-1:0]  pat_cnt [NUM_PAT];
  logic [PC_W-1:0]  pat_nxt [NUM_PAT];
  logic [SQ_W-1:0]  sq_sum;
  logic signed [ST_W-1:0] pk_stat;
  logic grp_done, win_end, take;

  assign take     = bit_valid && !clr;
  assign grp_full = {grp_sr[GRP_W-2:0], bit_in};
  assign grp_done = take && (grp_pos == 2'd3);
  assign win_end  = take && (bit_cnt == CNT_W'(WIN_BITS - 1));
  assign ones_nxt = ones_cnt + CNT_W'(bit_in);

  always_comb begin
    sq_sum = '0;
    for (int i = 0; i < NUM_PAT; i++) begin
      pat_nxt[i] = pat_cnt[i] + PC_W'(grp_done && (grp_full == GRP_W'(i)));
      sq_sum     = sq_sum + SQ_W'(pat_nxt[i]) * SQ_W'(pat_nxt[i]);
    end
    pk_stat = $signed(ST_W'({sq_sum, 4'b0000})) - $signed(ST_W'(NIBS * NIBS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_mono  <= 1'b0;
      fail_poker <= 1'b0;
    end else begin
      fail_mono  <= win_end && !(ones_nxt > CNT_W'(ONES_LO) && ones_nxt < CNT_W'(ONES_HI));
      fail_poker <= win_end && !(pk_stat > $signed(ST_W'(PK_LO)) && pk_stat < $signed(ST_W'(PK_HI)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr || win_end) begin
      bit_cnt  <= '0;
      ones_cnt <= '0;
      grp_sr   <= '0;
      grp_pos  <= '0;
      for (int i = 0; i < NUM_PAT; i++) pat_cnt[i] <= '0;
    end else if (bit_valid) begin
      bit_cnt  <= bit_cnt + 1'b1;
      ones_cnt <= ones_nxt;
      grp_sr   <= grp_full;
      grp_pos  <= grp_pos + 1'b1;
      for (int i = 0; i < NUM_PAT; i++) pat_cnt[i] <= pat_nxt[i];
    end
  end
endmodule

// File: rtl/ehm_run_detect.sv
module ehm_run_detect #(
  parameter int LIMIT = 34
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  output logic fail
);
  localparam int RW = $clog2(LIMIT + 1);
  logic [RW-1:0] run_len;
  logic          last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len  <= '0;
      last_bit <= 1'b0;
      fail     <= 1'b0;
    end else begin
      fail <= 1'b0;
      if (bit_valid) begin
        last_bit <= bit_in;
        if (run_len != '0 && bit_in == last_bit) begin
          if (run_len != RW'(LIMIT)) run_len <= run_len + 1'b1;
          fail <= (run_len == RW'(LIMIT - 1));
        end else begin
          run_len <= RW'(1);
          fail    <= (LIMIT == 1);
        end
      end
    end
  end
endmodule

// File: rtl/ehm_stuck_detect.sv
module ehm_stuck_detect #(
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             blk_valid,
  input  logic [BLK_W-1:0] blk_data,
  output logic             fail
);
  logic [BLK_W-1:0] prev_blk;
  logic             have_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_blk  <= '0;
      have_prev <= 1'b0;
      fail      <= 1'b0;
    end else if (clr) begin
      have_prev <= 1'b0;
      fail      <= 1'b0;
    end else begin
      fail <= blk_valid && have_prev && (blk_data == prev_blk);
      if (blk_valid) begin
        prev_blk  <= blk_data;
        have_prev <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/entropy_health_mon.sv
module entropy_health_mon #(
  parameter int WIN_BITS  = 20000,
  parameter int ONES_LO   = 9654,
  parameter int ONES_HI   = 10346,
  parameter int PK_LO     = 5150,
  parameter int PK_HI     = 287000,
  parameter int LONG_RUN  = 34,
  parameter int NOISE_RUN = 48,
  parameter int BLK_W     = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             blk_valid,
  input  logic [BLK_W-1:0] blk_data,
  output logic             fail_mono,
  output logic             fail_poker,
  output logic             fail_long,
  output logic             fail_noise,
  output logic             fail_stuck
);
  logic [1:0] run_fail;

  ehm_window_stats #(
    .WIN_BITS(WIN_BITS), .ONES_LO(ONES_LO), .ONES_HI(ONES_HI),
    .PK_LO(PK_LO), .PK_HI(PK_HI)
  ) u_win (
    .clk(clk), .rst(rst), .clr(clr), .bit_valid(bit_valid), .bit_in(bit_in),
    .fail_mono(fail_mono), .fail_poker(fail_poker)
  );

  for (genvar g = 0; g < 2; g++) begin : g_run
    ehm_run_detect #(.LIMIT(g == 0 ? LONG_RUN : NOISE_RUN)) u_run (
      .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
      .fail(run_fail[g])
    );
  end

  assign fail_long  = run_fail[0];
  assign fail_noise = run_fail[1];

  ehm_stuck_detect #(.BLK_W(BLK_W)) u_stuck (
    .clk(clk), .rst(rst), .clr(clr), .blk_valid(blk_valid),
    .blk_data(blk_data), .fail(fail_stuck)
  );
endmodule

// File: rtl/ehm_health_chk.sv
module ehm_health_chk (
  input logic clk,
  input logic rst,
  input logic clr,
  input logic bit_valid,
  input logic blk_valid,
  input logic fail_mono,
  input logic fail_poker,
  input logic fail_long,
  input logic fail_noise,
  input logic fail_stuck
);
  // R1
  mono_pulse_chk: assert property (@(posedge clk) disable iff (rst) fail_mono |=> !fail_mono);
  // R2
  mono_src_chk: assert property (@(posedge clk) disable iff (rst) fail_mono |-> $past(bit_valid && !clr));
  // R3
  poker_src_chk: assert property (@(posedge clk) disable iff (rst) fail_poker |-> $past(bit_valid && !clr));
  // R4
  long_src_chk: assert property (@(posedge clk) disable iff (rst) fail_long |-> $past(bit_valid));
  // R5
  noise_excl_chk: assert property (@(posedge clk) disable iff (rst) fail_noise |-> !fail_long && $past(bit_valid));
  // R7
  stuck_src_chk: assert property (@(posedge clk) disable iff (rst) fail_stuck |-> $past(blk_valid && !clr));
  // R8
  clr_quiet_chk: assert property (@(posedge clk) disable iff (rst) clr |=> !fail_mono && !fail_poker && !fail_stuck);
endmodule

bind entropy_health_mon ehm_health_chk u_chk (
  .clk(clk), .rst(rst), .clr(clr), .bit_valid(bit_valid), .blk_valid(blk_valid),
  .fail_mono(fail_mono), .fail_poker(fail_poker), .fail_long(fail_long),
  .fail_noise(fail_noise), .fail_stuck(fail_stuck)
);

// File: tb/tb_entropy_health_mon.sv
module tb_entropy_health_mon;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0, bit_valid = 1'b0, bit_in = 1'b0, blk_valid = 1'b0;
  logic [127:0] blk_data = '0;
  logic fail_mono, fail_poker, fail_long, fail_noise, fail_stuck;
  int checks = 0, errors = 0;
  logic [4:0] exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  entropy_health_mon dut (
    .clk(clk), .rst(rst), .clr(clr), .bit_valid(bit_valid), .bit_in(bit_in),
    .blk_valid(blk_valid), .blk_data(blk_data), .fail_mono(fail_mono),
    .fail_poker(fail_poker), .fail_long(fail_long), .fail_noise(fail_noise),
    .fail_stuck(fail_stuck)
  );

  // reference state, kept in requirement terms
  int m_bits = 0, m_ones = 0, m_gpos = 0, m_run = 0;
  int m_pk[16];
  logic [3:0] m_grp = '0;
  logic m_last = 1'b0, m_have = 1'b0;
  logic [127:0] m_prev = '0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic rbit();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng[0];
  endfunction

  // bit 0 mono, 1 poker, 2 long, 3 noise, 4 stuck
  task automatic step(input logic bv, input logic b, input logic kv,
                      input logic [127:0] k, input logic cl);
    logic [4:0] e;
    longint sq;
    e = '0;
    @(negedge clk);
    bit_valid = bv; bit_in = b; blk_valid = kv; blk_data = k; clr = cl;
    if (bv) begin // R4 R5 R6: runs ignore clr and gaps
      m_run = (m_run > 0 && b == m_last) ? m_run + 1 : 1;
      m_last = b;
      if (m_run == 34) e[2] = 1'b1;
      if (m_run == 48) e[3] = 1'b1;
    end
    if (cl) begin // R8
      m_bits = 0; m_ones = 0; m_gpos = 0; m_grp = '0; m_have = 1'b0;
      for (int i = 0; i < 16; i++) m_pk[i] = 0;
    end else begin
      if (bv) begin // R2 R3 R9
        m_bits++; m_ones += int'(b);
        m_grp = {m_grp[2:0], b}; m_gpos++;
        if (m_gpos == 4) begin m_pk[m_grp]++; m_gpos = 0; end
        if (m_bits == 20000) begin
          sq = 0;
          for (int i = 0; i < 16; i++) sq += longint'(m_pk[i]) * m_pk[i];
          sq = 16 * sq - 64'd25000000;
          e[0] = !(m_ones > 9654 && m_ones < 10346);
          e[1] = !(sq > 5150 && sq < 287000);
          m_bits = 0; m_ones = 0; m_gpos = 0;
          for (int i = 0; i < 16; i++) m_pk[i] = 0;
        end
      end
      if (kv) begin // R7
        e[4] = m_have && (k == m_prev);
        m_prev = k; m_have = 1'b1;
      end
    end
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  // monitor: pops one expected vector per cycle after reset
  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      logic [4:0] e, a;
      e = exp_q.pop_front();
      a = {fail_stuck, fail_noise, fail_long, fail_poker, fail_mono};
      for (int i = 0; i < 5; i++) begin
        checks++;
        if (a[i] !== e[i]) begin
          errors++;
          $display("FAIL %s at %0t: actual %b expected %b",
                   i == 0 ? "R2 mono" : i == 1 ? "R3 poker" : i == 2 ? "R4 long" :
                   i == 3 ? "R5 noise" : "R7 stuck", $time, a[i], e[i]);
        end
      end
    end
  end

  initial begin
    int k;
    for (int i = 0; i < 16; i++) m_pk[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    checks++;
    if ({fail_stuck, fail_noise, fail_long, fail_poker, fail_mono} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset: actual %b expected 00000",
               {fail_stuck, fail_noise, fail_long, fail_poker, fail_mono});
    end
    // R7 repeated blocks, first never stuck; R8 clear forgets block
    step(1'b0, 1'b0, 1'b1, {4{32'hA5A5_0001}}, 1'b0);
    step(1'b0, 1'b0, 1'b1, {4{32'hA5A5_0001}}, 1'b0);
    step(1'b0, 1'b0, 1'b1, {4{32'h0BAD_F00D}}, 1'b0);
    idle(2);
    step(1'b0, 1'b0, 1'b1, {4{32'h0BAD_F00D}}, 1'b0);
    step(1'b0, 1'b0, 1'b0, '0, 1'b1);
    step(1'b0, 1'b0, 1'b1, {4{32'h0BAD_F00D}}, 1'b0);
    step(1'b0, 1'b0, 1'b1, {4{32'h0BAD_F00D}}, 1'b1);
    step(1'b0, 1'b0, 1'b1, {4{32'h0BAD_F00D}}, 1'b0);
    idle(2);
    // R2 R3 R9: random window with idle gaps
    for (int i = 0; i < 20000; i++) begin
      if (i % 7 == 3) idle(1);
      step(1'b1, rbit(), 1'b0, '0, 1'b0);
    end
    idle(2);
    // R6 R8: run straddling a clear, clear restarts window
    for (int i = 0; i < 100; i++) step(1'b1, rbit(), 1'b0, '0, 1'b0);
    step(1'b1, 1'b0, 1'b0, '0, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, '0, 1'b0);
    step(1'b0, 1'b0, 1'b0, '0, 1'b1);
    for (int i = 0; i < 60; i++) step(1'b1, 1'b1, 1'b0, '0, 1'b0);
    for (int i = 60; i < 20000; i++) step(1'b1, rbit(), 1'b0, '0, 1'b0);
    // R3: alternating pattern, every group identical
    for (int i = 0; i < 20000; i++) step(1'b1, i[0] ? 1'b0 : 1'b1, 1'b0, '0, 1'b0);
    // R2 R3 R4 R5 R6: constant ones across window edges
    for (int i = 0; i < 20000; i++) step(1'b1, 1'b1, 1'b0, '0, 1'b0);
    // R2 boundaries: 10346 ones fails, 9655 ones passes
    for (int w = 0; w < 2; w++) begin
      k = (w == 0) ? 10346 : 9655;
      for (int i = 0; i < 20000; i++)
        step(1'b1, ((longint'(i + 1) * k) / 20000) != ((longint'(i) * k) / 20000),
             1'b0, '0, 1'b0);
    end
    idle(4);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 195000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule